// File: doc/BRIEF.md
# Windowed Watchdog Timeout Core

This block is the counting heart of a windowed watchdog. An up-counter starts from zero and advances on a counter tick. The tick comes either from every system clock cycle or from an external tick strobe, and is divided by a power of two. Once the count reaches the interrupt threshold, a sticky timeout-interrupt event is raised. Once it reaches the larger reset threshold, a sticky timeout-reset event is raised. Software keeps the watchdog alive by writing a fixed 32-bit key on the refresh port, which returns the counter to zero.

With window mode on, a keyed refresh is honoured only while the count lies inside a window. The window is a fraction of the reset threshold, set by a lower-edge code and an upper-increment code. A keyed refresh outside the window is rejected and recorded as a refresh violation. Two further controls scale or freeze the counting. A low-power rate setting can halt it or run it at a quarter, half or full rate. A debug control decides whether the counter keeps running while debug is active. Bus decoding and password unlocking are left to the surrounding logic.

Top module: `wdt_window_core`

## Requirements
- R1: After reset, `status`, `irq` and `wdt_rst` are all zero.
- R2: While `enable` is high with `clk_sel`=0, the counter advances by one every 2^`div_exp` clock cycles. While `enable` is low, the counter and the divider are held at zero.
- R3: With `clk_sel`=1, only cycles with `ext_tick` high feed the divider. With `ext_tick` low the counter does not move.
- R4: `status[4]` (timeout interrupt) is set in the cycle after the count is at or above `int_thresh`. `irq` equals `int_en` AND `status[4]`.
- R5: `status[5]` (timeout reset) is set in the cycle after the count is at or above `rst_thresh`. `wdt_rst` equals `rst_en` AND `status[5]`.
- R6: A refresh write with `refresh_data`=32'h5A45524F while enabled, and in the window when window mode is on, sets the counter to zero and clears `status[4]`. Any other data value has no effect.
- R7: Writing ones through `clr_wr`/`clr_mask` clears `status[0]` and `status[5]`, but never `status[4]`. A new set in the same cycle wins over the clear.
- R8: The lower window edge is `rst_thresh`×(8+2·`win_lo`)/16, rounded down, so codes 0..3 give 8/16, 10/16, 12/16 and 14/16.
- R9: The upper edge is the lower edge plus `rst_thresh`×k/16, rounded down, with k=8 for `win_up`=0, k=`win_up` for 1..6 and k=7 for 8. Code 7 and codes 9..15 put the upper edge at `rst_thresh` itself.
- R10: With `win_en`=1, a keyed refresh at a count below the lower edge, or at or above the upper edge, sets `status[0]` and leaves the counter running.
- R11: With `low_power`=1, `lp_rate` 0 halts counting, 1 passes every 4th divided tick, 2 passes every 2nd and 3 passes all of them.
- R12: With `dbg_active`=1 and `dbg_run`=0 the counter freezes. With `dbg_run`=1 it keeps counting.
- R13: The counter saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Watchdog enable |
| clk_sel | input | 1 | 0: count system cycles, 1: count `ext_tick` strobes |
| ext_tick | input | 1 | External tick strobe |
| div_exp | input | DIV_W | Divider exponent, divide by 2^div_exp |
| low_power | input | 1 | Low-power state indicator |
| lp_rate | input | 2 | Counting rate in low power (0 halt, 1 quarter, 2 half, 3 full) |
| dbg_active | input | 1 | Debug state indicator |
| dbg_run | input | 1 | Keep counting while debug is active |
| win_en | input | 1 | Window mode enable |
| win_lo | input | 2 | Lower window edge code |
| win_up | input | 4 | Upper window increment code |
| int_thresh | input | CNT_W | Interrupt timeout threshold |
| rst_thresh | input | CNT_W | Reset timeout threshold (larger than `int_thresh`) |
| int_en | input | 1 | Interrupt output enable |
| rst_en | input | 1 | Reset output enable |
| refresh_wr | input | 1 | Refresh write strobe |
| refresh_data | input | 32 | Refresh write data |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 6 | Write-one-to-clear mask |
| status | output | 6 | Events: bit 0 refresh violation, bit 4 timeout interrupt, bit 5 timeout reset |
| irq | output | 1 | Timeout interrupt |
| wdt_rst | output | 1 | Timeout reset request |

## Verification
The bench builds the core with CNT_W=10 and DIV_W=3. The narrow counter lets a run reach the all-ones value in about a thousand cycles, so saturation can be seen through a window refresh that only a saturated count would pass. The small divider width still covers every divider exponent. Window edges are probed exactly one count either side of each boundary for several lower and upper codes, including the full-period code. A behavioural model is compared with every output on every cycle through the low-power, debug and external-tick phases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [31:0] REFRESH_KEY = 32'h5A45524F;

  localparam int STAT_W    = 6;
  localparam int ST_VIOL   = 0;
  localparam int ST_TO_INT = 4;
  localparam int ST_TO_RST = 5;

  typedef enum logic [1:0] {
    LP_HALT    = 2'd0,
    LP_QUARTER = 2'd1,
    LP_HALF    = 2'd2,
    LP_FULL    = 2'd3
  } lp_rate_e;

  // Lower window edge in sixteenths of the reset threshold.
  function automatic logic [4:0] win_lo_sixteenths(input logic [1:0] code);
    return 5'd8 + {2'b00, code, 1'b0};
  endfunction

  // Upper window increment in sixteenths (meaningful when not full).
  function automatic logic [3:0] win_up_sixteenths(input logic [3:0] code);
    case (code)
      4'd0:    return 4'd8;
      4'd8:    return 4'd7;
      default: return code;
    endcase
  endfunction

  // Codes whose upper edge is the full reset period.
  function automatic logic win_up_full(input logic [3:0] code);
    return (code == 4'd7) || (code > 4'd8);
  endfunction

  // Whether a divided tick is passed on in the current rate phase.
  function automatic logic rate_pass(input logic low_power, input lp_rate_e rate,
                                     input logic [1:0] phase);
    if (!low_power) return 1'b1;
    case (rate)
      LP_FULL:    return 1'b1;
      LP_HALF:    return phase[0];
      LP_QUARTER: return phase == 2'd3;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wdt_window_calc.sv
module wdt_window_calc
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rst_thresh,
  input  logic [1:0]       lo_code,
  input  logic [3:0]       up_code,
  output logic             in_window
);
  localparam int EXT_W = CNT_W + 5;

  logic [EXT_W-1:0] full_ext, cnt_ext, lo_prod, inc_prod, lo_edge, up_edge;

  always_comb begin
    full_ext = EXT_W'(rst_thresh);
    cnt_ext  = EXT_W'(cnt);
    lo_prod  = full_ext * EXT_W'(win_lo_sixteenths(lo_code));
    inc_prod = full_ext * EXT_W'(win_up_sixteenths(up_code));
    lo_edge  = lo_prod >> 4;
    up_edge  = win_up_full(up_code) ? full_ext : lo_edge + (inc_prod >> 4);
    in_window = (cnt_ext >= lo_edge) && (cnt_ext < up_edge);
  end

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run_ok,
  input  logic             base_tick,
  input  logic [DIV_W-1:0] div_exp,
  input  logic             low_power,
  input  lp_rate_e         lp_rate,
  output logic             step
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q, wrap_at;
  logic [1:0]       phase_q;
  logic             advance, pre_tick;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) wrap_at[i] = (i < int'(div_exp));
    advance  = enable && run_ok && base_tick && !(low_power && lp_rate == LP_HALT);
    pre_tick = advance && (pre_q >= wrap_at);
    step     = pre_tick && rate_pass(low_power, lp_rate, phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (!enable) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else begin
      if (advance) pre_q <= pre_tick ? '0 : pre_q + 1'b1;
      if (pre_tick) phase_q <= phase_q + 2'd1;
    end
  end

endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              refresh_ok,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == ST_TO_INT) begin : g_refresh_cleared
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           status[i] <= 1'b0;
        else if (refresh_ok)  status[i] <= 1'b0;
        else if (set_vec[i])  status[i] <= 1'b1;
      end
    end else begin : g_w1c
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       status[i] <= 1'b0;
        else if (set_vec[i])              status[i] <= 1'b1;
        else if (clr_wr && clr_mask[i])   status[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdt_window_core.sv
module wdt_window_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              clk_sel,
  input  logic              ext_tick,
  input  logic [DIV_W-1:0]  div_exp,
  input  logic              low_power,
  input  logic [1:0]        lp_rate,
  input  logic              dbg_active,
  input  logic              dbg_run,
  input  logic              win_en,
  input  logic [1:0]        win_lo,
  input  logic [3:0]        win_up,
  input  logic [CNT_W-1:0]  int_thresh,
  input  logic [CNT_W-1:0]  rst_thresh,
  input  logic              int_en,
  input  logic              rst_en,
  input  logic              refresh_wr,
  input  logic [31:0]       refresh_data,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              wdt_rst
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt;
  logic              base_tick, run_ok, step;
  logic              key_ok, in_win, refresh_ok, viol_evt;
  logic              to_int_hit, to_rst_hit;
  logic [STAT_W-1:0] set_vec;

  assign base_tick = clk_sel ? ext_tick : 1'b1;
  assign run_ok    = !(dbg_active && !dbg_run);

  wdt_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .run_ok    (run_ok),
    .base_tick (base_tick),
    .div_exp   (div_exp),
    .low_power (low_power),
    .lp_rate   (lp_rate_e'(lp_rate)),
    .step      (step)
  );

  wdt_window_calc #(.CNT_W(CNT_W)) u_win (
    .cnt        (cnt),
    .rst_thresh (rst_thresh),
    .lo_code    (win_lo),
    .up_code    (win_up),
    .in_window  (in_win)
  );

  assign key_ok     = refresh_wr && enable && (refresh_data == REFRESH_KEY);
  assign refresh_ok = key_ok && (!win_en || in_win);
  assign viol_evt   = key_ok && win_en && !in_win;
  assign to_int_hit = enable && (cnt >= int_thresh);
  assign to_rst_hit = enable && (cnt >= rst_thresh);

  always_comb begin
    set_vec            = '0;
    set_vec[ST_VIOL]   = viol_evt;
    set_vec[ST_TO_INT] = to_int_hit;
    set_vec[ST_TO_RST] = to_rst_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!enable || refresh_ok)    cnt <= '0;
    else if (step && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end

  wdt_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .refresh_ok (refresh_ok),
    .clr_wr     (clr_wr),
    .clr_mask   (clr_mask),
    .status     (status)
  );

  assign irq     = int_en && status[ST_TO_INT];
  assign wdt_rst = rst_en && status[ST_TO_RST];

endmodule

// File: rtl/wdt_window_core_chk.sv
module wdt_window_core_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             dbg_active,
  input logic             dbg_run,
  input logic [CNT_W-1:0] int_thresh,
  input logic [CNT_W-1:0] rst_thresh,
  input logic             st_viol,
  input logic             st_int,
  input logic             st_rst,
  input logic [CNT_W-1:0] cnt,
  input logic             refresh_ok,
  input logic             viol_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0);

  // R4
  int_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_int) |-> ($past(enable) && ($past(cnt) >= $past(int_thresh))));

  // R5
  rst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_rst) |-> ($past(enable) && ($past(cnt) >= $past(rst_thresh))));

  // R6
  refresh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |=> cnt == '0);

  // R7
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_int) |-> $past(refresh_ok));

  // R10
  viol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> st_viol);

  // R10
  viol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(viol_evt && refresh_ok));

  // R12
  dbg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dbg_active && !dbg_run && !refresh_ok) |=> cnt == $past(cnt));

  // R13
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !refresh_ok && cnt == CNT_MAX) |=> cnt == CNT_MAX);

endmodule

bind wdt_window_core wdt_window_core_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .dbg_active (dbg_active),
  .dbg_run    (dbg_run),
  .int_thresh (int_thresh),
  .rst_thresh (rst_thresh),
  .st_viol    (status[wdt_pkg::ST_VIOL]),
  .st_int     (status[wdt_pkg::ST_TO_INT]),
  .st_rst     (status[wdt_pkg::ST_TO_RST]),
  .cnt        (cnt),
  .refresh_ok (refresh_ok),
  .viol_evt   (viol_evt)
);

// File: tb/wdt_window_core_tb_top.sv
module wdt_window_core_tb_top;
  localparam int CLK_P = 10;
  localparam int CW    = 10;
  localparam int DW    = 3;
  localparam int CMAX  = (1 << CW) - 1;
  localparam logic [31:0] KEY = 32'h5A45524F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, sel = 0, ext_tick = 0, lp = 0, dbg = 0, dbg_run = 0, win_en = 0;
  logic [DW-1:0] div = '0;
  logic [1:0] lpm = 2'd3, wlo = 2'd0;
  logic [3:0] wup = 4'd0;
  logic [CW-1:0] it = '0, rt = '0;
  logic int_en = 0, rst_en = 0, ref_wr = 0, clr_wr = 0;
  logic [31:0] ref_data = '0;
  logic [5:0] clr_mask = '0;
  logic [5:0] status;
  logic irq, wrst;

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_pre = 0, m_lpc = 0, m_cnt = 0;
  bit m_st0 = 0, m_st4 = 0, m_st5 = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt_window_core #(.CNT_W(CW), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(en), .clk_sel(sel), .ext_tick(ext_tick),
    .div_exp(div), .low_power(lp), .lp_rate(lpm), .dbg_active(dbg), .dbg_run(dbg_run),
    .win_en(win_en), .win_lo(wlo), .win_up(wup), .int_thresh(it), .rst_thresh(rt),
    .int_en(int_en), .rst_en(rst_en), .refresh_wr(ref_wr), .refresh_data(ref_data),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status), .irq(irq), .wdt_rst(wrst)
  );

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk) begin
    int lo, up, inc, mask;
    bit adv, ptick, stp, keyok, inwin, valid, viol, s4, s5;
    if (!rst_n) begin
      m_pre = 0; m_lpc = 0; m_cnt = 0; m_st0 = 0; m_st4 = 0; m_st5 = 0;
    end else begin
      mask  = (1 << int'(div)) - 1;
      adv   = en && !(dbg && !dbg_run) && !(lp && lpm == 2'd0) && (sel ? ext_tick : 1'b1);
      ptick = adv && (m_pre >= mask);
      stp   = ptick && (!lp || lpm == 2'd3 || (lpm == 2'd2 && (m_lpc % 2) == 1)
                        || (lpm == 2'd1 && m_lpc == 3));
      lo = (int'(rt) * (8 + 2 * int'(wlo))) / 16;
      if (wup == 4'd0) inc = 8;
      else if (wup == 4'd8) inc = 7;
      else inc = int'(wup);
      up = (wup == 4'd7 || wup > 4'd8) ? int'(rt) : lo + (int'(rt) * inc) / 16;
      keyok = ref_wr && en && ref_data == KEY;
      inwin = (m_cnt >= lo) && (m_cnt < up);
      valid = keyok && (!win_en || inwin);
      viol  = keyok && win_en && !inwin;
      s4 = en && m_cnt >= int'(it);
      s5 = en && m_cnt >= int'(rt);
      if (viol) m_st0 = 1; else if (clr_wr && clr_mask[0]) m_st0 = 0;
      if (valid) m_st4 = 0; else if (s4) m_st4 = 1;
      if (s5) m_st5 = 1; else if (clr_wr && clr_mask[5]) m_st5 = 0;
      if (!en) begin
        m_pre = 0; m_lpc = 0; m_cnt = 0;
      end else begin
        if (adv) m_pre = ptick ? 0 : m_pre + 1;
        if (ptick) m_lpc = (m_lpc + 1) % 4;
        if (valid) m_cnt = 0;
        else if (stp && m_cnt < CMAX) m_cnt = m_cnt + 1;
      end
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (status != {m_st5, m_st4, 3'b000, m_st0} || irq != (int_en & m_st4)
          || wrst != (rst_en & m_st5)) begin
        n_bad++;
        $display("FAIL %s model compare: actual status=%b irq=%b rst=%b expected status=%b irq=%b rst=%b",
                 cur_req, status, irq, wrst, {m_st5, m_st4, 3'b000, m_st0},
                 int_en & m_st4, rst_en & m_st5);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_refresh(input logic [31:0] d);
    ref_wr = 1; ref_data = d;
    cyc(1);
    ref_wr = 0;
  endtask

  task automatic restart();
    win_en = 0; ref_wr = 1; ref_data = KEY; clr_wr = 1; clr_mask = 6'h3F;
    cyc(1);
    ref_wr = 0;
    cyc(1);
    clr_wr = 0;
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) @(negedge clk);
    #1;
  endtask

  task automatic win_case(input logic [1:0] lo_c, input logic [3:0] up_c, input int v,
                          input int exp_viol);
    restart();
    win_en = 1; wlo = lo_c; wup = up_c;
    wait_cnt(v);
    do_refresh(KEY);
    chk(cur_req, int'(status[0]), exp_viol);
    clr_wr = 1; clr_mask = 6'h01;
    cyc(1);
    clr_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    cur_req = "R1";
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst", int'(wrst), 0);
    rst_n = 1;
    cyc(1);

    // R2 / R4: divide by 2, interrupt threshold 3
    cur_req = "R2";
    en = 1; div = 3'd1; it = 10'd3; rt = 10'd12; int_en = 1; rst_en = 0;
    cyc(6);
    chk("R4 before threshold", int'(status[4]), 0);
    cyc(1);
    chk("R4 at threshold", int'(status[4]), 1);
    chk("R4 irq", int'(irq), 1);
    cur_req = "R5";
    cyc(17);
    chk("R5 before reset threshold", int'(status[5]), 0);
    cyc(1);
    chk("R5 at reset threshold", int'(status[5]), 1);
    chk("R5 gated reset", int'(wrst), 0);
    rst_en = 1;
    cyc(1);
    chk("R5 reset output", int'(wrst), 1);

    // R6 / R7
    cur_req = "R6";
    do_refresh(KEY);
    chk("R6 refresh clears timeout int", int'(status[4]), 0);
    cur_req = "R7";
    clr_wr = 1; clr_mask = 6'h31;
    cyc(1);
    clr_wr = 0;
    chk("R7 w1c clears reset event", int'(status), 0);
    while (!m_st4) @(negedge clk);
    #1;
    clr_wr = 1; clr_mask = 6'h3F;
    cyc(1);
    clr_wr = 0;
    chk("R7 timeout int survives w1c", int'(status[4]), 1);
    cur_req = "R6";
    do_refresh(32'h5A45524E);
    chk("R6 wrong key ignored", int'(status[4]), 1);

    cur_req = "R2";
    en = 0;
    cyc(5);
    chk("R2 status sticky while disabled", int'(status[4]), 1);
    en = 1; div = 3'd3;
    restart();
    cyc(40);

    // R13: saturation observed through a window refresh
    cur_req = "R13";
    div = 3'd0; it = 10'd1000; rt = 10'd1020;
    restart();
    wait_cnt(CMAX);
    cyc(20);
    win_en = 1; wlo = 2'd3; wup = 4'd0;
    do_refresh(KEY);
    chk("R13 saturated count inside window", int'(status[0]), 0);

    // R8 / R9 / R10: window edges
    it = 10'd150; rt = 10'd160;
    cur_req = "R8";
    win_case(2'd0, 4'd1, 79, 1);
    win_case(2'd0, 4'd1, 80, 0);
    win_case(2'd2, 4'd8, 119, 1);
    win_case(2'd2, 4'd8, 120, 0);
    win_case(2'd1, 4'd6, 99, 1);
    win_case(2'd1, 4'd6, 100, 0);
    cur_req = "R9";
    win_case(2'd0, 4'd1, 89, 0);
    win_case(2'd0, 4'd1, 90, 1);
    win_case(2'd3, 4'd7, 159, 0);
    win_case(2'd3, 4'd7, 160, 1);
    win_case(2'd1, 4'd6, 159, 0);
    cur_req = "R10";
    win_case(2'd1, 4'd6, 160, 1);
    win_case(2'd2, 4'd8, 189, 0);
    win_case(2'd2, 4'd8, 190, 1);

    // R3: external tick source
    cur_req = "R3";
    sel = 1; ext_tick = 0; it = 10'd2; div = 3'd0;
    restart();
    cyc(30);
    chk("R3 no ticks no count", int'(status[4]), 0);
    for (int k = 0; k < 5; k++) begin
      ext_tick = 1; cyc(1);
      ext_tick = 0; cyc(2);
    end
    chk("R3 ext ticks count", int'(status[4]), 1);
    sel = 0;

    // R11: low-power rates
    cur_req = "R11";
    lp = 1; lpm = 2'd0; it = 10'd3;
    restart();
    cyc(40);
    chk("R11 halt", int'(status[4]), 0);
    lpm = 2'd1;
    restart();
    cyc(11);
    chk("R11 quarter", int'(status[4]), int'(m_st4));
    cyc(20);
    lpm = 2'd2;
    restart();
    cyc(6);
    chk("R11 half", int'(status[4]), int'(m_st4));
    lpm = 2'd3;
    restart();
    cyc(10);
    chk("R11 full", int'(status[4]), 1);
    lp = 0;

    // R12: debug freeze
    cur_req = "R12";
    dbg = 1; dbg_run = 0;
    restart();
    cyc(40);
    chk("R12 frozen", int'(status[4]), 0);
    dbg_run = 1;
    cyc(10);
    chk("R12 running in debug", int'(status[4]), 1);
    dbg = 0;
    cyc(5);

    finish_run();
  end

endmodule